// File: doc/BRIEF.md
# Receive Line Idle Timeout Timer

This block watches a serial receive line for inactivity. Each time the receiver reports a start bit, or software writes the restart strobe, a down-counter is loaded from a programmable timeout value. The counter then decrements once per bit-period tick. If it reaches zero before the next reload, the line is taken to have sat idle at its high level for the programmed period. The block then raises a sticky timeout flag and, when enabled, an interrupt request.

The 8-bit timeout value forms the upper bits of a 10-bit counter, and the low two bits are loaded as ones. A value of N therefore expires after 4*N+3 ticks. A value of zero turns the timer off. The receiver front end, the bus registers and the baud generator all sit outside this block.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset the flag (timeout_o) and the interrupt (irq_o) are 0, and the timer stays idle, with no flag, until the first reload.
- R2: A cycle with start_bit_i high loads {rto_i, 2'b11} into the counter. The flag rises at the clock edge of the (4*rto_i+3)-th tick_i that follows, and not before.
- R3: A cycle with restart_i high reloads the counter in the same way as R2. Every cycle that restart_i is high reloads, including consecutive cycles.
- R4: The counter changes only in cycles where tick_i is high. Cycles without a tick do not move the expiry.
- R5: When rto_i is 0 the timer is disabled. The flag is never set, and setting rto_i to 0 while the timer is counting stops it.
- R6: Reaching zero sets the flag once. The counter then stays stopped, and further ticks do not set the flag again until the next reload.
- R7: The flag is sticky and is cleared by a cycle with clr_i high. If an expiry and clr_i fall in the same cycle, the flag is set.
- R8: irq_o is high exactly when the flag is set and irq_en_i is high.
- R9: If a reload and the zero-reaching tick fall in the same cycle, the reload wins. The flag is not set, and a full period starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rto_i | input | 8 | Programmed timeout value; 0 disables |
| tick_i | input | 1 | One-cycle pulse per bit period |
| start_bit_i | input | 1 | Start bit detected by receiver |
| restart_i | input | 1 | Software restart strobe |
| clr_i | input | 1 | Write-one-to-clear for the flag |
| irq_en_i | input | 1 | Interrupt enable |
| timeout_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions are checked on every cycle. They check that the flag only rises on a tick, with a nonzero value and no reload in the previous cycle, and that it only falls after a clear. They also check that each reload puts the expected value into the counter, and that the interrupt stays low while it is disabled. Only the bench scenarios can show the exact tick count to expiry for each programmed value. The same holds for the stop after expiry and for a restart strobe held over consecutive cycles.

// File: rtl/rx_idle_timeout_pkg.sv
package rx_idle_timeout_pkg;
  localparam int unsigned RTO_W_DEF  = 8;
  localparam int unsigned FRAC_W_DEF = 2;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/rx_idle_timeout_reload.sv
module rx_idle_timeout_reload #(
  parameter int unsigned RTO_W  = 8,
  parameter int unsigned FRAC_W = 2,
  localparam int unsigned CNT_W = RTO_W + FRAC_W
) (
  input  logic [RTO_W-1:0] rto_i,
  input  logic             start_bit_i,
  input  logic             restart_i,
  output logic             reload_o,
  output logic             enabled_o,
  output logic [CNT_W-1:0] load_val_o
);
  // restart is level-qualified each cycle, no edge detect
  assign reload_o   = start_bit_i | restart_i;
  assign enabled_o  = |rto_i;
  assign load_val_o = {rto_i, {FRAC_W{1'b1}}};
endmodule

// File: rtl/rx_idle_timeout_cnt.sv
module rx_idle_timeout_cnt
  import rx_idle_timeout_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic             enabled_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  tmr_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic            last_step;

  assign last_step = (state_q == TMR_RUN) && tick_i && (cnt_q == CNT_W'(1));
  // reload has priority over a zero reach in the same cycle
  assign expire_o  = last_step && enabled_i && !reload_i;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else if (reload_i) begin
      if (enabled_i) begin
        state_q <= TMR_RUN;
        cnt_q   <= load_val_i;
      end else begin
        state_q <= TMR_IDLE;
        cnt_q   <= '0;
      end
    end else if (!enabled_i) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else if (state_q == TMR_RUN && tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) state_q <= TMR_IDLE;
    end
  end
endmodule

// File: rtl/rx_idle_timeout_flag.sv
module rx_idle_timeout_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // set beats clear so an expiry is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rx_idle_timeout_pkg::*;
#(
  parameter int unsigned RTO_W  = RTO_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  localparam int unsigned CNT_W = RTO_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RTO_W-1:0] rto_i,
  input  logic             tick_i,
  input  logic             start_bit_i,
  input  logic             restart_i,
  input  logic             clr_i,
  input  logic             irq_en_i,
  output logic             timeout_o,
  output logic             irq_o
);
  logic             reload;
  logic             enabled;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  rx_idle_timeout_reload #(.RTO_W(RTO_W), .FRAC_W(FRAC_W)) u_reload (
    .rto_i       (rto_i),
    .start_bit_i (start_bit_i),
    .restart_i   (restart_i),
    .reload_o    (reload),
    .enabled_o   (enabled),
    .load_val_o  (load_val)
  );

  rx_idle_timeout_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (reload),
    .enabled_i  (enabled),
    .load_val_i (load_val),
    .tick_i     (tick_i),
    .cnt_o      (cnt_q),
    .expire_o   (expire)
  );

  rx_idle_timeout_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .clr_i    (clr_i),
    .irq_en_i (irq_en_i),
    .flag_o   (timeout_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk #(
  parameter int unsigned RTO_W  = 8,
  parameter int unsigned FRAC_W = 2,
  localparam int unsigned CNT_W = RTO_W + FRAC_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RTO_W-1:0] rto_i,
  input logic             tick_i,
  input logic             start_bit_i,
  input logic             restart_i,
  input logic             clr_i,
  input logic             irq_en_i,
  input logic             timeout_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_q
);
  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_bit_i && rto_i != '0) |=> cnt_q == {$past(rto_i), {FRAC_W{1'b1}}});

  // R3
  restart_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && rto_i != '0) |=> cnt_q == {$past(rto_i), {FRAC_W{1'b1}}});

  // R4
  tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(tick_i));

  // R5
  disabled_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(rto_i) != '0);

  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !clr_i) |=> timeout_o);

  // R7
  clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> $past(clr_i));

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i || !timeout_o) |-> !irq_o);

  // R9
  reload_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !$past(start_bit_i) && !$past(restart_i));
endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.RTO_W(RTO_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rto_i       (rto_i),
  .tick_i      (tick_i),
  .start_bit_i (start_bit_i),
  .restart_i   (restart_i),
  .clr_i       (clr_i),
  .irq_en_i    (irq_en_i),
  .timeout_o   (timeout_o),
  .irq_o       (irq_o),
  .cnt_q       (cnt_q)
);

// File: tb/rx_idle_timeout_bench.sv
module rx_idle_timeout_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] rto_i = '0;
  logic       tick_i = 1'b0;
  logic       start_bit_i = 1'b0;
  logic       restart_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       timeout_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  rx_idle_timeout u_rx_idle_timeout (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rto_i       (rto_i),
    .tick_i      (tick_i),
    .start_bit_i (start_bit_i),
    .restart_i   (restart_i),
    .clr_i       (clr_i),
    .irq_en_i    (irq_en_i),
    .timeout_o   (timeout_o),
    .irq_o       (irq_o)
  );

  typedef struct packed {
    logic [7:0]  rto;
    logic        en;
    logic        via_restart;
    logic [10:0] exp_ticks;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{rto: 8'd1,   en: 1'b1, via_restart: 1'b0, exp_ticks: 11'd7},
    '{rto: 8'd2,   en: 1'b0, via_restart: 1'b1, exp_ticks: 11'd11},
    '{rto: 8'd5,   en: 1'b1, via_restart: 1'b1, exp_ticks: 11'd23},
    '{rto: 8'd3,   en: 1'b1, via_restart: 1'b0, exp_ticks: 11'd15},
    '{rto: 8'd255, en: 1'b1, via_restart: 1'b0, exp_ticks: 11'd1023}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  // one cycle of stimulus, starting and ending at a negedge
  task automatic cyc(input logic t, input logic s, input logic r, input logic c);
    tick_i = t; start_bit_i = s; restart_i = r; clr_i = c;
    @(negedge clk_i);
    tick_i = 1'b0; start_bit_i = 1'b0; restart_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state and no expiry before any reload
    chk("R1 flag after reset", timeout_o, 1'b0);
    chk("R1 irq after reset", irq_o, 1'b0);
    rto_i = 8'd1; irq_en_i = 1'b1;
    ticks(20);
    chk("R1 idle without reload", timeout_o, 1'b0);

    // vector table: R2/R3 exact expiry, R4 gaps, R6 stop, R7 clear, R8 irq
    for (int v = 0; v < NVEC; v++) begin
      rto_i = VEC[v].rto;
      irq_en_i = VEC[v].en;
      if (VEC[v].via_restart) cyc(1'b0, 1'b0, 1'b1, 1'b0);
      else                    cyc(1'b0, 1'b1, 1'b0, 1'b0);
      ticks(int'(VEC[v].exp_ticks) - 1);
      repeat (4) cyc(1'b0, 1'b0, 1'b0, 1'b0);
      chk(VEC[v].via_restart ? "R3 no flag before last tick" : "R2 no flag before last tick",
          timeout_o, 1'b0);
      chk("R4 no tick no expiry", timeout_o, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      chk(VEC[v].via_restart ? "R3 flag on last tick" : "R2 flag on last tick",
          timeout_o, 1'b1);
      chk("R8 irq follows enable", irq_o, VEC[v].en);
      ticks(5);
      chk("R7 sticky", timeout_o, 1'b1);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R7 cleared", timeout_o, 1'b0);
      ticks(10);
      chk("R6 stopped after expiry", timeout_o, 1'b0);
    end

    // R5: zero value disables
    irq_en_i = 1'b1;
    rto_i = 8'd0;
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(40);
    chk("R5 zero value never sets", timeout_o, 1'b0);
    rto_i = 8'd1;
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(3);
    rto_i = 8'd0;
    ticks(3);
    rto_i = 8'd1;
    ticks(10);
    chk("R5 zero mid-count stops timer", timeout_o, 1'b0);

    // R9: reload on the zero-reaching tick wins
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(6);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9 reload beats expiry", timeout_o, 1'b0);
    ticks(6);
    chk("R9 full period restarted", timeout_o, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 expiry after new period", timeout_o, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);

    // R3: restart held over consecutive cycles reloads each time
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    ticks(5);
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    ticks(6);
    chk("R3 held restart reloads", timeout_o, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3 expiry after held restart", timeout_o, 1'b1);

    // R8: enable gates the interrupt while flag is set
    irq_en_i = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 irq masked", irq_o, 1'b0);
    irq_en_i = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 irq unmasked", irq_o, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);

    // R7: set wins over a same-cycle clear
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(6);
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R7 set wins over clear", timeout_o, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 clear after set", timeout_o, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule